// File: doc/BRIEF.md
# NAND page command/address sequencer

This block produces the command and address byte stream that opens a page operation on a raw 8-bit NAND device. One start pulse selects one of two sequences. The page-open sequence sends an opcode, a zero column address and the page number. The column-seek sequence moves the read pointer inside a page that is already open. How many column and page address bytes are sent depends on two inputs together: the page size and the device's address-cycle count.

Each byte appears on `dq_out` while `wr_strobe` is high. `cle` marks a command byte and `ale` marks an address byte, so a bus adapter can map them to the command-latch and address-latch offsets of the chip window. After the last byte the block can poll the device ready line at a fixed interval, up to a fixed number of polls, and it flags a timeout if the device never becomes ready. A page size that is not supported is refused before any byte is emitted.

Top module: `nand_opseq`

## Requirements
- R1: After reset `busy`, `done`, `wr_strobe`, `cle`, `ale`, `size_err` and `timeout` are all 0.
- R2: A command byte is presented with `cle`=1 and `ale`=0, an address byte with `ale`=1 and `cle`=0. Neither latch line is high while `wr_strobe` is low.
- R3: A page-open sequence (`op_seek`=0) starts with the command `opcode`. Next comes a column address of zero: one byte 0x00 when `page_bytes`=512, and two bytes 0x00 when `page_bytes` is 2048 or 4096.
- R4: After the column bytes, page bits 7:0 and then 15:8 are sent. Let E = `addr_cycles` minus 1 when `page_bytes`=512, else E = `addr_cycles` (3-bit wrap). When E is nonzero, bits 23:16 follow. When E equals 2, bits 31:24 follow as well.
- R5: When `read_go`=1 and `page_bytes` is above 512, a page-open sequence ends with the command 0x30. For 512-byte pages no such command is added.
- R6: A seek sequence (`op_seek`=1) sends the command 0x05 and then `column[7:0]`. For pages above 512 bytes it then sends `column[15:8]` and the command 0xE0.
- R7: With `wait_ready`=1, the block samples `nand_rdy` every POLL_DIV cycles after the last byte. It finishes on the first sample that reads 1. If POLL_BUDGET samples all read 0, it finishes with `timeout`=1, no earlier than POLL_BUDGET*POLL_DIV cycles after the last byte.
- R8: A `start` that arrives while `busy`=1 is ignored. The running sequence is not changed and no extra bytes are emitted.
- R9: `busy` is high from the cycle after an accepted start until completion. `done` is high for exactly one cycle, in the same cycle that `busy` falls.
- R10: Each byte holds `wr_strobe` high for exactly STROBE_CYC cycles (default 2). One low cycle separates consecutive bytes.
- R11: A start with `page_bytes` other than 512, 2048 or 4096 emits no byte and leaves `busy` low. It sets `size_err` and pulses `done` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a sequence (taken only when idle) |
| op_seek | input | 1 | 0 = page open, 1 = column seek |
| opcode | input | 8 | Command byte for a page open |
| page_addr | input | 32 | Page number |
| column | input | 16 | Column for a seek |
| page_bytes | input | 13 | Page size in bytes |
| addr_cycles | input | 3 | Device address-cycle count |
| read_go | input | 1 | Append the read-start command on large pages |
| wait_ready | input | 1 | Poll ready after the last byte |
| nand_rdy | input | 1 | Device ready bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| size_err | output | 1 | Last request had an unsupported page size |
| timeout | output | 1 | Last ready poll ran out of budget |
| wr_strobe | output | 1 | Byte valid strobe |
| cle | output | 1 | Command latch qualifier |
| ale | output | 1 | Address latch qualifier |
| dq_out | output | 8 | Byte value |

## Verification
A wrong byte count or a wrong byte index shows up as a missing, extra or reordered byte on `dq_out`, and it appears in the first sequence that uses the affected page size and cycle count. A corrupted pacing counter shows as a strobe of the wrong width, which is visible on the first byte. A stuck poller state shows up only after the full poll window, either as `done` never arriving or as `timeout` set against a ready device. The bench therefore waits out that window. A broken busy gate shows as extra bytes from a start that should have been ignored, within a few cycles of that start.

// File: rtl/nand_opseq_pkg.sv
package nand_opseq_pkg;
  localparam int SEQ_MAX = 8;
  localparam int SEQ_IW  = $clog2(SEQ_MAX);
  localparam int SEQ_NW  = SEQ_IW + 1;

  localparam logic [7:0] OPC_COL_OUT = 8'h05;
  localparam logic [7:0] OPC_COL_GO  = 8'hE0;
  localparam logic [7:0] OPC_READ_GO = 8'h30;

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] val;
  } seq_ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_POLL} seq_state_t;
endpackage

// File: rtl/nand_opseq_build.sv
module nand_opseq_build
  import nand_opseq_pkg::*;
(
  input  logic                op_seek,
  input  logic [7:0]          opcode,
  input  logic [31:0]         page_addr,
  input  logic [15:0]         column,
  input  logic [12:0]         page_bytes,
  input  logic [2:0]          addr_cycles,
  input  logic                read_go,
  output seq_ent_t            ents [SEQ_MAX],
  output logic [SEQ_NW-1:0]   n_ents,
  output logic                size_ok
);
  logic       small_pg;
  logic [2:0] extra;

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < SEQ_MAX; i++) ents[i] = '0;
    small_pg = (page_bytes == 13'd512);
    size_ok  = small_pg || (page_bytes == 13'd2048) || (page_bytes == 13'd4096);
    extra    = addr_cycles - {2'b00, small_pg};
    if (!op_seek) begin
      ents[k] = '{1'b1, opcode};            k = k + 1;
      ents[k] = '{1'b0, 8'h00};             k = k + 1;
      if (!small_pg) begin
        ents[k] = '{1'b0, 8'h00};           k = k + 1;
      end
      ents[k] = '{1'b0, page_addr[7:0]};    k = k + 1;
      ents[k] = '{1'b0, page_addr[15:8]};   k = k + 1;
      if (extra != 3'd0) begin
        ents[k] = '{1'b0, page_addr[23:16]}; k = k + 1;
      end
      if (extra == 3'd2) begin
        ents[k] = '{1'b0, page_addr[31:24]}; k = k + 1;
      end
      if (read_go && !small_pg) begin
        ents[k] = '{1'b1, OPC_READ_GO};     k = k + 1;
      end
    end else begin
      ents[k] = '{1'b1, OPC_COL_OUT};       k = k + 1;
      ents[k] = '{1'b0, column[7:0]};       k = k + 1;
      if (!small_pg) begin
        ents[k] = '{1'b0, column[15:8]};    k = k + 1;
        ents[k] = '{1'b1, OPC_COL_GO};      k = k + 1;
      end
    end
    n_ents = SEQ_NW'(k);
  end
endmodule

// File: rtl/nand_opseq_pacer.sv
module nand_opseq_pacer #(
  parameter int STROBE_CYC = 2,
  localparam int CW = $clog2(STROBE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic strobe,
  output logic slot_end
);
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign strobe   = run_q && (cnt_q < CW'(STROBE_CYC));
  assign slot_end = run_q && (cnt_q == CW'(STROBE_CYC));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (kick) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (slot_end) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/nand_opseq_poll.sv
module nand_opseq_poll #(
  parameter int POLL_DIV    = 8,
  parameter int POLL_BUDGET = 100,
  localparam int DW = $clog2(POLL_DIV + 1),
  localparam int BW = $clog2(POLL_BUDGET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic rdy,
  output logic fin,
  output logic tmo
);
  logic          act_q, act_d;
  logic [DW-1:0] div_q, div_d;
  logic [BW-1:0] pol_q, pol_d;
  logic          tick, last_poll;

  assign tick      = act_q && (div_q == DW'(POLL_DIV - 1));
  assign last_poll = (pol_q == BW'(POLL_BUDGET - 1));
  assign fin       = tick && (rdy || last_poll);
  assign tmo       = fin && !rdy;

  always_comb begin
    act_d = act_q;
    div_d = div_q;
    pol_d = pol_q;
    if (kick) begin
      act_d = 1'b1;
      div_d = '0;
      pol_d = '0;
    end else if (fin) begin
      act_d = 1'b0;
    end else if (tick) begin
      div_d = '0;
      pol_d = pol_q + BW'(1);
    end else if (act_q) begin
      div_d = div_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      div_q <= '0;
      pol_q <= '0;
    end else begin
      act_q <= act_d;
      div_q <= div_d;
      pol_q <= pol_d;
    end
  end
endmodule

// File: rtl/nand_opseq.sv
module nand_opseq
  import nand_opseq_pkg::*;
#(
  parameter int STROBE_CYC  = 2,
  parameter int POLL_DIV    = 8,
  parameter int POLL_BUDGET = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_seek,
  input  logic [7:0]  opcode,
  input  logic [31:0] page_addr,
  input  logic [15:0] column,
  input  logic [12:0] page_bytes,
  input  logic [2:0]  addr_cycles,
  input  logic        read_go,
  input  logic        wait_ready,
  input  logic        nand_rdy,
  output logic        busy,
  output logic        done,
  output logic        size_err,
  output logic        timeout,
  output logic        wr_strobe,
  output logic        cle,
  output logic        ale,
  output logic [7:0]  dq_out
);
  seq_ent_t          ents_w [SEQ_MAX];
  seq_ent_t          ents_q [SEQ_MAX];
  logic [SEQ_NW-1:0] n_w, n_q;
  logic [SEQ_IW-1:0] idx_q, idx_d;
  logic              size_ok;
  seq_state_t        state_q, state_d;
  logic              wait_q;
  logic              done_q, done_d, err_q, err_d, tmo_q, tmo_d;
  logic              accept, refuse, last_ent, pace_kick, poll_kick;
  logic              pace_strobe, slot_end, poll_fin, poll_tmo;
  seq_ent_t          cur;

  nand_opseq_build u_build (
    .op_seek(op_seek), .opcode(opcode), .page_addr(page_addr),
    .column(column), .page_bytes(page_bytes), .addr_cycles(addr_cycles),
    .read_go(read_go), .ents(ents_w), .n_ents(n_w), .size_ok(size_ok)
  );

  nand_opseq_pacer #(.STROBE_CYC(STROBE_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .kick(pace_kick),
    .strobe(pace_strobe), .slot_end(slot_end)
  );

  nand_opseq_poll #(.POLL_DIV(POLL_DIV), .POLL_BUDGET(POLL_BUDGET)) u_poll (
    .clk(clk), .rst_n(rst_n), .kick(poll_kick), .rdy(nand_rdy),
    .fin(poll_fin), .tmo(poll_tmo)
  );

  assign accept    = start && (state_q == ST_IDLE) && size_ok;
  assign refuse    = start && (state_q == ST_IDLE) && !size_ok;
  assign last_ent  = ({1'b0, idx_q} == (n_q - SEQ_NW'(1)));
  assign pace_kick = accept || ((state_q == ST_EMIT) && slot_end && !last_ent);
  assign poll_kick = (state_q == ST_EMIT) && slot_end && last_ent && wait_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    err_d   = err_q;
    tmo_d   = tmo_q;
    if (refuse) begin
      err_d  = 1'b1;
      tmo_d  = 1'b0;
      done_d = 1'b1;
    end
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_EMIT;
        idx_d   = '0;
        err_d   = 1'b0;
        tmo_d   = 1'b0;
      end
      ST_EMIT: if (slot_end) begin
        if (!last_ent) begin
          idx_d = idx_q + SEQ_IW'(1);
        end else if (wait_q) begin
          state_d = ST_POLL;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_POLL: if (poll_fin) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        tmo_d   = poll_tmo;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      for (int i = 0; i < SEQ_MAX; i++) ents_q[i] <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
      if (accept) begin
        n_q    <= n_w;
        wait_q <= wait_ready;
        for (int i = 0; i < SEQ_MAX; i++) ents_q[i] <= ents_w[i];
      end
    end
  end

  assign cur       = ents_q[idx_q];
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign size_err  = err_q;
  assign timeout   = tmo_q;
  assign wr_strobe = pace_strobe;
  assign cle       = pace_strobe && cur.is_cmd;
  assign ale       = pace_strobe && !cur.is_cmd;
  assign dq_out    = pace_strobe ? cur.val : 8'h00;
endmodule

// File: rtl/nand_opseq_chk.sv
module nand_opseq_chk #(
  parameter int STROBE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic size_err,
  input logic timeout,
  input logic wr_strobe,
  input logic cle,
  input logic ale
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (wr_strobe) hi_cnt <= hi_cnt + 8'd1;
    else                hi_cnt <= '0;
  end

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r2_latch_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale) |-> wr_strobe);
  a_r10_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strobe) |-> (hi_cnt == 8'(STROBE_CYC)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (!busy && !wr_strobe));
  a_r7_timeout_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

bind nand_opseq nand_opseq_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .size_err(size_err), .timeout(timeout), .wr_strobe(wr_strobe),
  .cle(cle), .ale(ale)
);

// File: tb/nand_opseq_bench.sv
module nand_opseq_bench;
  localparam int PDIV = 8;
  localparam int PBUD = 100;

  typedef struct packed {
    logic        seek;
    logic [7:0]  opc;
    logic [31:0] pg;
    logic [15:0] col;
    logic [12:0] psz;
    logic [2:0]  acyc;
    logic        rgo;
    logic [3:0]  exp_n;
  } stim_t;

  localparam int NV = 8;
  localparam stim_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h00123456, 16'h0000, 13'd512,  3'd3, 1'b0, 4'd6},
    '{1'b0, 8'h80, 32'hA1B2C3D4, 16'h0000, 13'd2048, 3'd5, 1'b0, 4'd6},
    '{1'b0, 8'h00, 32'h0001F00E, 16'h0000, 13'd2048, 3'd2, 1'b1, 4'd8},
    '{1'b0, 8'h80, 32'h00000777, 16'h0000, 13'd4096, 3'd1, 1'b0, 4'd6},
    '{1'b0, 8'h00, 32'h00004321, 16'h0000, 13'd512,  3'd1, 1'b1, 4'd4},
    '{1'b1, 8'h00, 32'h00000000, 16'h0234, 13'd2048, 3'd2, 1'b0, 4'd4},
    '{1'b1, 8'h00, 32'h00000000, 16'h01A5, 13'd512,  3'd2, 1'b0, 4'd2},
    '{1'b0, 8'h85, 32'hDEADBEEF, 16'h0000, 13'd4096, 3'd2, 1'b0, 4'd7}
  };

  logic clk, rst_n, start, op_seek, read_go, wait_ready, nand_rdy;
  logic [7:0] opcode;
  logic [31:0] page_addr;
  logic [15:0] column;
  logic [12:0] page_bytes;
  logic [2:0] addr_cycles;
  logic busy, done, size_err, timeout, wr_strobe, cle, ale;
  logic [7:0] dq_out;

  int checks = 0, fails = 0;
  int cap_n = 0;
  logic [7:0] cap_b [64];
  logic       cap_c [64];
  logic       cap_bad_kind [64];
  logic prev_st = 1'b0;
  int hi_len = 0, bad_width = 0, gap_len = 0, bad_gap = 0;

  nand_opseq #(.STROBE_CYC(2), .POLL_DIV(PDIV), .POLL_BUDGET(PBUD)) u_nand_opseq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_seek(op_seek), .opcode(opcode),
    .page_addr(page_addr), .column(column), .page_bytes(page_bytes),
    .addr_cycles(addr_cycles), .read_go(read_go), .wait_ready(wait_ready),
    .nand_rdy(nand_rdy), .busy(busy), .done(done), .size_err(size_err),
    .timeout(timeout), .wr_strobe(wr_strobe), .cle(cle), .ale(ale), .dq_out(dq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural responder: capture each byte on the strobe's rising edge
  always @(negedge clk) begin
    if (wr_strobe && !prev_st) begin
      if (!prev_st && gap_len < 1 && cap_n > 0) bad_gap = bad_gap + 1;
      cap_b[cap_n % 64] = dq_out;
      cap_c[cap_n % 64] = cle;
      cap_bad_kind[cap_n % 64] = (cle == ale);
      cap_n = cap_n + 1;
    end
    if (wr_strobe) begin
      hi_len = hi_len + 1;
      gap_len = 0;
    end else begin
      if (prev_st && hi_len != 2) bad_width = bad_width + 1;
      hi_len = 0;
      gap_len = gap_len + 1;
    end
    prev_st = wr_strobe;
  end

  initial begin
    #900000;
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model(input stim_t s, output logic [63:0] bs, output logic [7:0] ks);
    int k;
    logic sm;
    logic [2:0] e;
    k = 0; bs = '0; ks = '0;
    sm = (s.psz == 13'd512);
    e = s.acyc - {2'b00, sm};
    if (!s.seek) begin
      bs[k*8 +: 8] = s.opc; ks[k] = 1'b1; k++;
      k++;
      if (!sm) k++;
      bs[k*8 +: 8] = s.pg[7:0];  k++;
      bs[k*8 +: 8] = s.pg[15:8]; k++;
      if (e != 3'd0) begin bs[k*8 +: 8] = s.pg[23:16]; k++; end
      if (e == 3'd2) begin bs[k*8 +: 8] = s.pg[31:24]; k++; end
      if (s.rgo && !sm) begin bs[k*8 +: 8] = 8'h30; ks[k] = 1'b1; k++; end
    end else begin
      bs[k*8 +: 8] = 8'h05; ks[k] = 1'b1; k++;
      bs[k*8 +: 8] = s.col[7:0]; k++;
      if (!sm) begin
        bs[k*8 +: 8] = s.col[15:8]; k++;
        bs[k*8 +: 8] = 8'hE0; ks[k] = 1'b1; k++;
      end
    end
    return k;
  endfunction

  task automatic apply(input stim_t s, input logic wr);
    op_seek = s.seek; opcode = s.opc; page_addr = s.pg; column = s.col;
    page_bytes = s.psz; addr_cycles = s.acyc; read_go = s.rgo; wait_ready = wr;
  endtask

  // start one request and wait for done; returns cycles until done
  task automatic run(input stim_t s, input logic wr, output int cyc, output logic done_ok);
    @(negedge clk);
    apply(s, wr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    done_ok = !done;
  endtask

  task automatic compare(input stim_t s, input int base, input string tag);
    logic [63:0] eb;
    logic [7:0]  ek;
    logic [63:0] ab;
    logic [7:0]  ak;
    logic        kind_err;
    int n;
    n = model(s, eb, ek);
    check({tag, " byte count"}, 64'(cap_n - base), 64'(n));
    ab = '0; ak = '0; kind_err = 1'b0;
    for (int j = 0; j < n && j < 8; j++) begin
      ab[j*8 +: 8] = cap_b[(base + j) % 64];
      ak[j]        = cap_c[(base + j) % 64];
      kind_err     = kind_err | cap_bad_kind[(base + j) % 64];
    end
    check({tag, " byte stream"}, ab, eb);
    check({tag, " R2 latch kinds"}, {55'd0, kind_err, ak}, {56'd0, ek});
  endtask

  initial begin
    int cyc, base;
    logic dok;
    stim_t s;
    rst_n = 1'b0; start = 1'b0; nand_rdy = 1'b0;
    apply(VEC[0], 1'b0);
    repeat (3) @(negedge clk);
    // R1: idle outputs during and right after reset
    check("R1 reset outputs", {57'd0, busy, done, wr_strobe, cle, ale, size_err, timeout}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {59'd0, busy, done, wr_strobe, size_err, timeout}, 64'd0);

    // table walk: R3 R4 R5 R6 stream contents
    for (int v = 0; v < NV; v++) begin
      base = cap_n;
      run(VEC[v], 1'b0, cyc, dok);
      check($sformatf("R3/R4 vec%0d table count", v), 64'(cap_n - base), 64'(VEC[v].exp_n));
      compare(VEC[v], base, $sformatf("R4 R5 R6 vec%0d", v));
      check($sformatf("R9 vec%0d done single", v), {63'd0, dok}, 64'd1);
    end

    // R10 strobe width and gap over all bytes so far
    check("R10 strobe width", 64'(bad_width), 64'd0);
    check("R10 strobe gap", 64'(bad_gap), 64'd0);

    // R11 unsupported size
    s = VEC[1]; s.psz = 13'd1024;
    base = cap_n;
    run(s, 1'b0, cyc, dok);
    check("R11 size_err set", {63'd0, size_err}, 64'd1);
    check("R11 no bytes", 64'(cap_n - base), 64'd0);
    check("R11 done within 2 cycles", 64'(cyc <= 2), 64'd1);

    // R8 start while busy is ignored
    base = cap_n;
    @(negedge clk);
    apply(VEC[7], 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 busy while running", {63'd0, busy}, 64'd1);
    apply(VEC[5], 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    compare(VEC[7], base, "R8 ignored start");
    check("R11 size_err cleared", {63'd0, size_err}, 64'd0);

    // R7 ready already high: finishes after first poll, no timeout
    nand_rdy = 1'b1;
    base = cap_n;
    run(VEC[5], 1'b1, cyc, dok);
    check("R7 ready no timeout", {63'd0, timeout}, 64'd0);
    check("R7 ready prompt finish", 64'(cyc < 4 * 3 + PDIV + 6), 64'd1);

    // R7 ready never: timeout after the full budget
    nand_rdy = 1'b0;
    run(VEC[6], 1'b1, cyc, dok);
    check("R7 timeout flagged", {63'd0, timeout}, 64'd1);
    check("R7 timeout not early", 64'(cyc >= PBUD * PDIV), 64'd1);
    check("R9 done single after poll", {63'd0, dok}, 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule